// File: doc/BRIEF.md
# Four-Lane Sample Interleaver

This block turns four parallel sample lanes, each updated once per slow period, into one sample stream that advances on every core clock cycle. A two-bit phase counter runs on the core clock. Its low bit is the core clock divided by two and its high bit is the core clock divided by four. Together the two bits pick which captured lane drives the registered output. The block also exports a slow clock made from the same counter. The upstream source launches new lane data on the falling edge of that clock, and the block captures all lanes together on its rising edge.

A mode strap selects how many lanes take part. With the strap high, all four lanes are interleaved and the slow clock runs at a quarter of the core rate. With the strap low, only lanes A and B are used, the divide-by-four select is held at zero, and the slow clock runs at half the core rate. Samples are offset-binary words, from 0x000 (minimum) to 0xFFF (maximum), and they pass through unaltered. The strap is meant to be static, so it is changed only while reset is asserted.

Top module: `lane_interleaver`

## Requirements
- R1: While the synchronous reset is sampled high, the output word is cleared to 0x000 and the exported slow clock is driven high. The phase counter is returned to phase 0.
- R2: With the strap high (four-lane mode), the output carries lane A, then lane B, then lane C, then lane D, one word per core cycle. Lane A appears on the first core edge after the capture edge.
- R3: In four-lane mode, the slow clock has a period of four core cycles, high for two cycles and low for two. It rises on the same edge on which the lanes are captured.
- R4: With the strap low (two-lane mode), the output alternates lane A and lane B, one word per core cycle. Lanes C and D never reach the output.
- R5: In two-lane mode, the slow clock has a period of two core cycles, high for one cycle and low for one. It rises on the capture edge.
- R6: Lane inputs are sampled only on the capture edge. A change on the lanes at any other edge does not alter the words already being emitted.
- R7: Every bit of a sample passes through unchanged, including the extreme codes 0x000 and 0xFFF and alternating bit patterns.
- R8: A reset asserted in the middle of a frame realigns the phase. After release, the next rising edge of the slow clock captures a fresh frame, and lane A of that frame comes out first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; one output word per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_four | input | 1 | Strap: 1 selects four-lane interleave, 0 selects two-lane interleave |
| lane_a | input | 12 | Lane A sample, emitted first in each frame |
| lane_b | input | 12 | Lane B sample, emitted second |
| lane_c | input | 12 | Lane C sample, emitted third in four-lane mode |
| lane_d | input | 12 | Lane D sample, emitted fourth in four-lane mode |
| dout | output | 12 | Registered interleaved output word |
| slow_clk | output | 1 | Exported divided clock for the upstream source |

## Verification
On every cycle, the assertions check the reset values and the shape of the slow clock in each mode. They also check that the first words after each rise of the slow clock equal the lane values held at the capture edge. Only the bench scenarios show two other behaviours. The first is that lanes C and D stay out of the output in two-lane mode. The second is that lane changes between capture edges have no effect on the output. The bench scenarios also cover realignment after a reset in mid-frame and the extreme codes, because both need a chosen stimulus sequence.

// File: rtl/lane_interleaver.sv
module lane_interleaver #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_four,
  input  logic [W-1:0] lane_a,
  input  logic [W-1:0] lane_b,
  input  logic [W-1:0] lane_c,
  input  logic [W-1:0] lane_d,
  output logic [W-1:0] dout,
  output logic         slow_clk
);
  localparam int NLANE = 4;

  logic [1:0]   ph;
  logic [1:0]   ph_nxt;
  logic         cap_edge;
  logic         s0;
  logic         s1;
  logic [W-1:0] cap [NLANE];

  // phase counter: bit 0 is core/2, bit 1 is core/4
  assign ph_nxt   = mode_four ? ph + 2'd1 : {1'b0, ~ph[0]};
  assign cap_edge = mode_four ? (ph == 2'd3) : ph[0];
  assign s0       = ph[0];
  assign s1       = ph[1] & mode_four;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= 2'd0;
      slow_clk <= 1'b1;
      dout     <= '0;
      for (int i = 0; i < NLANE; i++) cap[i] <= '0;
    end else begin
      ph       <= ph_nxt;
      slow_clk <= mode_four ? ~ph_nxt[1] : ~ph_nxt[0];
      dout     <= cap[{s1, s0}];
      if (cap_edge) begin
        cap[0] <= lane_a;
        cap[1] <= lane_b;
        cap[2] <= lane_c;
        cap[3] <= lane_d;
      end
    end
  end
endmodule

// File: rtl/lane_interleaver_chk.sv
module lane_interleaver_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         mode_four,
  input logic [W-1:0] lane_a,
  input logic [W-1:0] lane_b,
  input logic [W-1:0] lane_c,
  input logic [W-1:0] dout,
  input logic         slow_clk
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (dout == '0) && slow_clk);

  // R2
  first_lane_a_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(slow_clk) |=> dout == $past(lane_a, 2));

  // R4
  second_lane_b_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(slow_clk) |=> ##1 dout == $past(lane_b, 3));

  // R2
  third_lane_c_chk: assert property (@(posedge clk) disable iff (rst)
    mode_four && $past(mode_four) && $rose(slow_clk) |=> ##2 dout == $past(lane_c, 4));

  // R3
  four_high_two_chk: assert property (@(posedge clk) disable iff (rst)
    mode_four && $past(mode_four) && $rose(slow_clk) |=> slow_clk ##1 !slow_clk);

  // R3
  four_low_two_chk: assert property (@(posedge clk) disable iff (rst)
    mode_four && $past(mode_four) && $fell(slow_clk) |=> !slow_clk ##1 slow_clk);

  // R5
  two_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_four && $past(!mode_four) && !$past(rst) |=> slow_clk != $past(slow_clk));
endmodule

bind lane_interleaver lane_interleaver_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .mode_four(mode_four), .lane_a(lane_a),
  .lane_b(lane_b), .lane_c(lane_c), .dout(dout), .slow_clk(slow_clk)
);

// File: tb/lane_interleaver_tb_top.sv
module lane_interleaver_tb_top;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode_four = 1'b1;
  logic [W-1:0] lane_a = '0, lane_b = '0, lane_c = '0, lane_d = '0;
  logic [W-1:0] dout;
  logic         slow_clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lane_interleaver #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .mode_four(mode_four),
    .lane_a(lane_a), .lane_b(lane_b), .lane_c(lane_c), .lane_d(lane_d),
    .dout(dout), .slow_clk(slow_clk)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int seed, input int f, input int k);
    return W'((seed * 613 + f * 149 + k * 1031 + 7) & 12'hFFF);
  endfunction

  function automatic logic [W-1:0] extreme(input int f, input int k);
    case ((f + k) % 4)
      0: return 12'h000;
      1: return 12'hFFF;
      2: return 12'hAAA;
      default: return 12'h555;
    endcase
  endfunction

  task automatic put(input int seed, input int f, input bit ext);
    lane_a = ext ? extreme(f, 0) : pat(seed, f, 0);
    lane_b = ext ? extreme(f, 1) : pat(seed, f, 1);
    lane_c = ext ? extreme(f, 2) : pat(seed, f, 2);
    lane_d = ext ? extreme(f, 3) : pat(seed, f, 3);
  endtask

  task automatic do_reset(input logic four);
    @(negedge clk);
    rst = 1'b1;
    mode_four = four;
    lane_a = 12'h123; lane_b = 12'h456; lane_c = 12'h789; lane_d = 12'hABC;
    repeat (2) @(negedge clk);
    check("R1 dout during reset", dout, '0);
    check("R1 slow_clk during reset", W'(slow_clk), W'(1));
    rst = 1'b0;
  endtask

  // Streams n frames; the bench's own frame f lanes are pat(seed,f,k).
  task automatic stream(input string req, input int seed, input int n, input bit glitch, input bit ext);
    int nl = mode_four ? 4 : 2;
    bit prev;
    while (slow_clk !== 1'b0) @(negedge clk);
    put(seed, 0, ext);
    prev = slow_clk;
    @(negedge clk);
    while (!(slow_clk && !prev)) begin
      prev = slow_clk;
      @(negedge clk);
    end
    for (int f = 0; f < n; f++) begin
      bit driven = 0;
      for (int k = 0; k < nl; k++) begin
        bit exp_slow = (k == nl - 1) || (nl == 4 && k == 0);
        @(negedge clk);
        check(req, dout, ext ? extreme(f, k) : pat(seed, f, k));
        check(mode_four ? "R3 slow clock shape" : "R5 slow clock shape",
              W'(slow_clk), W'(exp_slow));
        if (glitch && k == 0 && slow_clk) begin
          lane_a = ~pat(seed, f, 0); lane_b = ~pat(seed, f, 1);
          lane_c = ~pat(seed, f, 2); lane_d = ~pat(seed, f, 3);
        end
        if (!driven && !slow_clk) begin
          driven = 1;
          put(seed, f + 1, ext);
          if (!mode_four) begin
            lane_c = ~lane_a; lane_d = ~lane_b;
          end
        end
      end
    end
  endtask

  task automatic t_reset_state;
    do_reset(1'b1);
    @(negedge clk);
    check("R1 first word after reset", dout, '0);
  endtask

  task automatic t_four_order;
    do_reset(1'b1);
    stream("R2 four-lane order", 3, 6, 0, 0);
  endtask

  task automatic t_two_order;
    do_reset(1'b0);
    stream("R4 two-lane order, C/D ignored", 11, 8, 0, 0);
  endtask

  task automatic t_hold;
    do_reset(1'b1);
    stream("R6 lanes held between captures", 21, 5, 1, 0);
  endtask

  task automatic t_extremes;
    do_reset(1'b1);
    stream("R7 extreme codes four-lane", 0, 4, 0, 1);
    do_reset(1'b0);
    stream("R7 extreme codes two-lane", 0, 4, 0, 1);
  endtask

  task automatic t_mid_reset;
    do_reset(1'b1);
    stream("R8 before mid reset", 5, 2, 0, 0);
    @(negedge clk);
    do_reset(1'b1);
    stream("R8 realigned after mid reset", 9, 3, 0, 0);
  endtask

  initial begin
    t_reset_state();
    t_four_order();
    t_two_order();
    t_hold();
    t_extremes();
    t_mid_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule